// File: doc/BRIEF.md
# Asynchronous DRAM Bus Cycle Classifier

This block watches the control strobes of an asynchronous page-mode DRAM bus from a synchronous clock domain and names every memory cycle it sees. The row strobe, the two byte-lane column strobes, the write enable, the output enable and a flag that shows when the memory is driving the data bus are passed through a synchronizer. A state machine then follows the order in which the strobes change. When the row strobe is released, the block reports the cycle type, the byte lanes that took part and a protocol-error flag, all with a one-cycle valid pulse. It is meant for use as a bus checker next to a memory model or as a snoop that feeds a transaction log. It stores no data and measures no analog timing.

Mode selection uses the OR of the two column strobes. The first lane to assert opens the column phase, and the phase closes only when both lanes are released. Write behaviour is still tracked per lane, so that a byte-lane mismatch can be flagged.

The state machine has seven states:
- IDLE: no row strobe.
- ROW: row asserted, no column yet.
- COL: column access in progress.
- CBR: refresh started with a column already low.
- HOLD: row released after a read while the column is still held.
- HIDE: row asserted again while a read's column is held.
- TAIL: row released after any other cycle while a column is still low.

The transitions are:
- IDLE→ROW or IDLE→CBR when the row strobe asserts. The choice depends on the column level in the sample before.
- ROW→COL when a column asserts.
- ROW→IDLE when the row is released.
- COL→IDLE, COL→HOLD or COL→TAIL when the row is released.
- CBR→IDLE or CBR→TAIL when the row is released.
- HOLD→HIDE when the row asserts again.
- HOLD→IDLE when the columns are released.
- HIDE→HOLD or HIDE→IDLE when the row is released.
- TAIL→CBR when the row asserts.
- TAIL→IDLE when the columns are released.

Top module: `edo_cycle_classifier`

## Requirements
- R1: After reset, `cyc_valid`, `lane_hi`, `lane_lo` and `proto_err` are 0. `cyc_kind` reads 0 (standby) in every cycle in which `cyc_valid` is low.
- R2: Each row-strobe pulse produces exactly one one-cycle `cyc_valid` pulse. The pulse comes after the release of the row strobe. `cyc_kind` carries the code: 0 standby, 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 column-before-row refresh, 7 hidden refresh.
- R3: A row pulse with no column strobe asserted gives code 5, with both lane flags at 0.
- R4: If either column strobe is asserted in the sample before the row strobe asserts, the cycle gives code 6 with `proto_err` at 0. The lane flags show which column strobes were low.
- R5: If write enable is high at the first column assertion and stays high, the cycle gives code 1.
- R6: If write enable is low at the first column assertion, the cycle gives code 2. If the memory drives the data bus while a column is asserted in that cycle, `proto_err` is set.
- R7: If write enable falls while a column is asserted, after a first column assertion that found it high, the cycle gives code 4 when output enable was asserted with a column low before that fall. Otherwise it gives code 3.
- R8: After a read whose row release left a column held low, a new row pulse while the column stays held gives a second report with code 7. Releasing the held column without a new row pulse gives no report.
- R9: `lane_hi` and `lane_lo` show which column strobes went low during the cycle. A cycle that uses only one lane is legal and gives no error on its own.
- R10: When both lanes are used and write enable differs between the two lanes' first assertions, `proto_err` is set.
- R11: When the second lane asserts more than SKEW_MAX samples after the first lane, `proto_err` is set. A gap of SKEW_MAX samples or less is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_hi_n | input | 1 | Upper byte column strobe, active low |
| cas_lo_n | input | 1 | Lower byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_drv_n | input | 1 | Low while the memory drives the data bus |
| cyc_valid | output | 1 | One-cycle pulse marking a finished cycle |
| cyc_kind | output | 3 | Cycle code, per R2 |
| lane_hi | output | 1 | Upper lane took part in the cycle |
| lane_lo | output | 1 | Lower lane took part in the cycle |
| proto_err | output | 1 | Protocol error in the reported cycle |

## Verification
The assertions assume that every strobe level lasts at least one clock sample, and that the row strobe stays released for at least two samples between cycles. Without this, a release and a new assertion could be seen in the same synchronized sample. They also assume that the write-enable fall and the output-enable assertion never land in the same sample, and that the second lane never asserts in the same sample as the row release. The bench changes inputs only on the falling clock edge and holds each phase for at least one full clock. It randomizes lane choice, skew and cycle type only inside these limits, and places the skew values on both sides of SKEW_MAX.

// File: rtl/edo_mon_pkg.sv
package edo_mon_pkg;

    typedef enum logic [2:0] {
        K_STANDBY = 3'd0,
        K_READ    = 3'd1,
        K_EARLY   = 3'd2,
        K_DELAYED = 3'd3,
        K_RMW     = 3'd4,
        K_RASONLY = 3'd5,
        K_CBR     = 3'd6,
        K_HIDDEN  = 3'd7
    } cyc_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROW,
        S_COL,
        S_CBR,
        S_HOLD,
        S_HIDE,
        S_TAIL
    } mon_state_e;

endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '1;
                else        stg[i] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '1;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/edo_skew_timer.sv
module edo_skew_timer #(
    parameter int SKEW_MAX = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic track_i,
    input  logic hi_a,
    input  logic lo_a,
    output logic err_o
);
    localparam int LIM = SKEW_MAX + 1;
    localparam int CW  = $clog2(LIM + 1);

    logic          seen_hi, seen_lo;
    logic [CW-1:0] gap;
    logic          one_seen, late_hit;

    assign one_seen = seen_hi ^ seen_lo;
    assign late_hit = one_seen && ((hi_a && !seen_hi) || (lo_a && !seen_lo))
                      && (gap > CW'(SKEW_MAX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_hi <= 1'b0;
            seen_lo <= 1'b0;
            gap     <= '0;
            err_o   <= 1'b0;
        end else if (!track_i) begin
            seen_hi <= 1'b0;
            seen_lo <= 1'b0;
            gap     <= '0;
            err_o   <= 1'b0;
        end else begin
            seen_hi <= seen_hi | hi_a;
            seen_lo <= seen_lo | lo_a;
            if (!seen_hi && !seen_lo && (hi_a || lo_a))
                gap <= CW'(1);
            else if (one_seen && gap < CW'(LIM))
                gap <= gap + CW'(1);
            if (late_hit) err_o <= 1'b1;
        end
    end

    // R11: the skew error appears only once both lanes have been seen
    p_skew_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (seen_hi && seen_lo));
endmodule

// File: rtl/edo_cycle_fsm.sv
module edo_cycle_fsm
    import edo_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ras_a,
    input  logic       cu_a,
    input  logic       cl_a,
    input  logic       we_a,
    input  logic       oe_a,
    input  logic       drv_a,
    input  logic       skew_err_i,
    output logic       track_o,
    output logic       cyc_valid_o,
    output logic [2:0] kind_o,
    output logic       lane_hi_o,
    output logic       lane_lo_o,
    output logic       err_o
);
    mon_state_e state, nxt;
    cyc_kind_e  emit_kind, col_kind;
    logic emit, emit_err, start, orcas, prev_or, we_prev;
    logic seen_u, seen_l, early_u, early_l, first_early, late_we, oe_rd, drv_err;
    logic mismatch, in_col;

    assign orcas    = cu_a | cl_a;
    assign in_col   = (state == S_ROW) || (state == S_COL);
    assign track_o  = in_col;
    assign mismatch = seen_u && seen_l && (early_u != early_l);

    always_comb begin
        if (first_early)  col_kind = K_EARLY;
        else if (late_we) col_kind = oe_rd ? K_RMW : K_DELAYED;
        else              col_kind = K_READ;
    end

    always_comb begin
        nxt       = state;
        emit      = 1'b0;
        emit_kind = K_STANDBY;
        emit_err  = 1'b0;
        start     = 1'b0;
        unique case (state)
            S_IDLE: if (ras_a) begin
                start = 1'b1;
                nxt   = prev_or ? S_CBR : S_ROW;
            end
            S_ROW: if (!ras_a) begin
                emit = 1'b1; emit_kind = K_RASONLY; nxt = S_IDLE;
            end else if (orcas) nxt = S_COL;
            S_COL: if (!ras_a) begin
                emit      = 1'b1;
                emit_kind = col_kind;
                emit_err  = skew_err_i | mismatch | drv_err;
                nxt = orcas ? ((col_kind == K_READ) ? S_HOLD : S_TAIL) : S_IDLE;
            end
            S_CBR: if (!ras_a) begin
                emit = 1'b1; emit_kind = K_CBR;
                nxt  = orcas ? S_TAIL : S_IDLE;
            end
            S_HOLD: if (!orcas) nxt = S_IDLE;
                    else if (ras_a) begin start = 1'b1; nxt = S_HIDE; end
            S_HIDE: if (!ras_a) begin
                emit = 1'b1; emit_kind = K_HIDDEN;
                nxt  = orcas ? S_HOLD : S_IDLE;
            end
            S_TAIL: if (!orcas) nxt = S_IDLE;
                    else if (ras_a) begin start = 1'b1; nxt = S_CBR; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_or <= 1'b0; we_prev <= 1'b0;
            seen_u <= 1'b0; seen_l <= 1'b0; early_u <= 1'b0; early_l <= 1'b0;
            first_early <= 1'b0; late_we <= 1'b0; oe_rd <= 1'b0; drv_err <= 1'b0;
        end else begin
            prev_or <= orcas;
            we_prev <= we_a;
            if (start) begin
                seen_u <= (nxt == S_ROW) ? 1'b0 : cu_a;
                seen_l <= (nxt == S_ROW) ? 1'b0 : cl_a;
                early_u <= 1'b0; early_l <= 1'b0; first_early <= 1'b0;
                late_we <= 1'b0; oe_rd <= 1'b0; drv_err <= 1'b0;
            end else if (in_col) begin
                if (cu_a && !seen_u) begin seen_u <= 1'b1; early_u <= we_a; end
                if (cl_a && !seen_l) begin seen_l <= 1'b1; early_l <= we_a; end
                if (orcas && !seen_u && !seen_l) first_early <= we_a;
                if (state == S_COL && orcas) begin
                    if (we_a && !we_prev && !first_early) late_we <= 1'b1;
                    if (oe_a && !late_we) oe_rd <= 1'b1;
                    if (first_early && drv_a) drv_err <= 1'b1;
                end
            end else if (state == S_CBR || state == S_HIDE) begin
                seen_u <= seen_u | cu_a;
                seen_l <= seen_l | cl_a;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_valid_o <= 1'b0; kind_o <= K_STANDBY;
            lane_hi_o <= 1'b0; lane_lo_o <= 1'b0; err_o <= 1'b0;
        end else begin
            cyc_valid_o <= emit;
            kind_o      <= emit ? emit_kind : K_STANDBY;
            lane_hi_o   <= emit & seen_u;
            lane_lo_o   <= emit & seen_l;
            err_o       <= emit & emit_err;
        end
    end

    // R1: the code is standby whenever no report is being made
    p_kind_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid_o |-> (kind_o == K_STANDBY));
    // R2: a report lasts one cycle and follows a row release
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid_o |=> !cyc_valid_o);
    p_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid_o |-> !$past(ras_a));
    // R3: a row-only refresh never reports lanes
    p_rasonly_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid_o && kind_o == K_RASONLY) |-> (!lane_hi_o && !lane_lo_o));
    // R9: an access cycle reports at least one lane
    p_access_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid_o && kind_o >= K_READ && kind_o <= K_RMW) |-> (lane_hi_o || lane_lo_o));
    // R4: refresh reports never carry an error
    p_refresh_noerr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid_o && kind_o >= K_RASONLY) |-> !err_o);
endmodule

// File: rtl/edo_cycle_classifier.sv
module edo_cycle_classifier #(
    parameter int SYNC_STAGES = 2,
    parameter int SKEW_MAX    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ras_n,
    input  logic       cas_hi_n,
    input  logic       cas_lo_n,
    input  logic       we_n,
    input  logic       oe_n,
    input  logic       dq_drv_n,
    output logic       cyc_valid,
    output logic [2:0] cyc_kind,
    output logic       lane_hi,
    output logic       lane_lo,
    output logic       proto_err
);
    localparam int NSIG = 6;

    logic [NSIG-1:0] raw_n, syn_n, act;
    logic            track, skew_err;

    assign raw_n = {dq_drv_n, oe_n, we_n, cas_lo_n, cas_hi_n, ras_n};
    assign act   = ~syn_n;

    edo_strobe_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_n), .q_o(syn_n)
    );

    edo_skew_timer #(.SKEW_MAX(SKEW_MAX)) u_skew (
        .clk(clk), .rst_n(rst_n), .track_i(track),
        .hi_a(act[1]), .lo_a(act[2]), .err_o(skew_err)
    );

    edo_cycle_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ras_a(act[0]), .cu_a(act[1]), .cl_a(act[2]),
        .we_a(act[3]), .oe_a(act[4]), .drv_a(act[5]),
        .skew_err_i(skew_err), .track_o(track),
        .cyc_valid_o(cyc_valid), .kind_o(cyc_kind),
        .lane_hi_o(lane_hi), .lane_lo_o(lane_lo), .err_o(proto_err)
    );
endmodule

// File: tb/test_edo_cycle_classifier.sv
module test_edo_cycle_classifier;
    localparam int SKEW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ras_n = 1'b1, cas_hi_n = 1'b1, cas_lo_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, dq_drv_n = 1'b1;
    logic cyc_valid, lane_hi, lane_lo, proto_err;
    logic [2:0] cyc_kind;

    int n_checks = 0, n_errors = 0, n_ev = 0, n_idle_bad = 0;
    int ev_kind, ev_hi, ev_lo, ev_err;
    bit wd_hit = 1'b0;

    always #5 clk = ~clk;

    edo_cycle_classifier #(.SYNC_STAGES(2), .SKEW_MAX(SKEW)) i_edo_cycle_classifier (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_hi_n(cas_hi_n), .cas_lo_n(cas_lo_n),
        .we_n(we_n), .oe_n(oe_n), .dq_drv_n(dq_drv_n), .cyc_valid(cyc_valid),
        .cyc_kind(cyc_kind), .lane_hi(lane_hi), .lane_lo(lane_lo), .proto_err(proto_err)
    );

    always @(negedge clk) begin
        if (rst_n && cyc_valid) begin
            n_ev++;
            ev_kind = int'(cyc_kind); ev_hi = int'(lane_hi);
            ev_lo = int'(lane_lo); ev_err = int'(proto_err);
        end else if (rst_n && cyc_kind != 3'd0) n_idle_bad++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_kind(input int mode);
        return mode + 1;   // 0 read->1, 1 early->2, 2 delayed->3, 3 rmw->4
    endfunction

    task automatic expect_ev(input int n0, input int k, input int hi, input int lo,
                             input int err, input string req);
        chk(n_ev == n0 + 1, {req, " report count"}, n_ev, n0 + 1);
        chk(ev_kind == k, {req, " kind"}, ev_kind, k);
        chk(ev_hi == hi && ev_lo == lo, {req, " lanes"}, ev_hi * 2 + ev_lo, hi * 2 + lo);
        chk(ev_err == err, {req, " error flag"}, ev_err, err);
    endtask

    // mode: 0 read, 1 early write, 2 delayed write, 3 read-modify-write
    task automatic access(input bit hi, input bit lo, input int mode, input int skew,
                          input bit drv, input string req);
        int n0 = n_ev;
        int e;
        ras_n = 1'b0; tick(2);
        if (mode == 1) begin we_n = 1'b0; tick(1); end
        if (hi && lo) begin
            cas_hi_n = 1'b0;
            if (skew > 0) tick(skew);
            cas_lo_n = 1'b0;
        end else if (hi) cas_hi_n = 1'b0;
        else cas_lo_n = 1'b0;
        tick(2);
        if (drv) begin dq_drv_n = 1'b0; tick(1); dq_drv_n = 1'b1; end
        case (mode)
            0: begin oe_n = 1'b0; tick(2); end
            2: begin we_n = 1'b0; tick(2); end
            3: begin oe_n = 1'b0; tick(2); oe_n = 1'b1; tick(1); we_n = 1'b0; tick(2); end
            default: tick(1);
        endcase
        cas_hi_n = 1'b1; cas_lo_n = 1'b1; tick(1);
        ras_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick(8);
        e = ((hi && lo && skew > SKEW) || (drv && mode == 1)) ? 1 : 0;
        expect_ev(n0, exp_kind(mode), int'(hi), int'(lo), e, req);
    endtask

    task automatic ras_only(input string req);
        int n0 = n_ev;
        ras_n = 1'b0; tick(4); ras_n = 1'b1; tick(8);
        expect_ev(n0, 5, 0, 0, 0, req);
    endtask

    task automatic cbr(input bit hi, input bit lo, input string req);
        int n0 = n_ev;
        cas_hi_n = ~hi; cas_lo_n = ~lo; tick(2);
        ras_n = 1'b0; tick(4); ras_n = 1'b1; tick(2);
        cas_hi_n = 1'b1; cas_lo_n = 1'b1; tick(8);
        expect_ev(n0, 6, int'(hi), int'(lo), 0, req);
    endtask

    task automatic run();
        int n0;
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(2);
        // R1: reset state
        chk(!cyc_valid && cyc_kind == 0 && !lane_hi && !lane_lo && !proto_err,
            "R1 reset outputs", int'(cyc_valid), 0);

        ras_only("R3 row-only refresh");
        cbr(1'b1, 1'b1, "R4 cbr both lanes");
        cbr(1'b0, 1'b1, "R4 cbr one lane");
        access(1'b1, 1'b1, 0, 0, 1'b0, "R5 read word");
        access(1'b1, 1'b1, 1, 0, 1'b0, "R6 early write");
        access(1'b0, 1'b1, 1, 0, 1'b1, "R6 early write with bus driven");
        access(1'b1, 1'b1, 2, 0, 1'b0, "R7 delayed write");
        access(1'b1, 1'b1, 3, 0, 1'b0, "R7 read-modify-write");
        access(1'b1, 1'b0, 0, 0, 1'b0, "R9 upper lane only");
        access(1'b0, 1'b1, 2, 0, 1'b0, "R9 lower lane only");
        access(1'b1, 1'b1, 0, SKEW, 1'b0, "R11 skew at limit");
        access(1'b1, 1'b1, 0, SKEW + 1, 1'b0, "R11 skew over limit");

        // R10: lower lane asserts with write high, upper with write low
        n0 = n_ev;
        ras_n = 1'b0; tick(2); cas_lo_n = 1'b0; tick(1);
        we_n = 1'b0; tick(1); cas_hi_n = 1'b0; tick(2);
        cas_hi_n = 1'b1; cas_lo_n = 1'b1; tick(1);
        ras_n = 1'b1; we_n = 1'b1; tick(8);
        expect_ev(n0, 3, 1, 1, 1, "R10 lane write mismatch");

        // R8: hidden refresh after a read with the column held
        n0 = n_ev;
        ras_n = 1'b0; tick(2); cas_hi_n = 1'b0; cas_lo_n = 1'b0; tick(2);
        oe_n = 1'b0; tick(2); ras_n = 1'b1; tick(8);
        expect_ev(n0, 1, 1, 1, 0, "R8 read before hidden");
        n0 = n_ev;
        ras_n = 1'b0; tick(4); ras_n = 1'b1; tick(8);
        expect_ev(n0, 7, 1, 1, 0, "R8 hidden refresh");
        n0 = n_ev;
        cas_hi_n = 1'b1; cas_lo_n = 1'b1; oe_n = 1'b1; tick(8);
        chk(n_ev == n0, "R8 release of held column gives no report", n_ev, n0);

        // constrained random mix, fixed seed
        for (int i = 0; i < 40; i++) begin
            int m = $urandom_range(0, 5);
            int lanes = $urandom_range(1, 3);
            bit hi = lanes[1], lo = lanes[0];
            if (m <= 3) begin
                int sk = (hi && lo) ? $urandom_range(0, SKEW + 2) : 0;
                bit dv = (m == 1) ? 1'($urandom_range(0, 1)) : 1'b0;
                access(hi, lo, m, sk, dv, "R2 random access");
            end else if (m == 4) ras_only("R3 random");
            else cbr(hi, lo, "R4 random");
        end

        chk(n_idle_bad == 0, "R1 kind standby while not valid", n_idle_bad, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        fork
            run();
            begin repeat (150000) @(posedge clk); wd_hit = 1'b1; end
        join_any
        disable fork;
        if (wd_hit) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=1 expected=0");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule